// File: doc/BRIEF.md
# Serial-Loaded Synthesizer Control Register

This block holds the eight control bits of a frequency synthesizer and uses them to shape the synthesizer's outputs. A host writes a byte over a three-wire port. It pulls the active-low enable `ser_en_n` low, presents each bit on `ser_dat`, and raises `ser_clk` once per bit, most significant bit first. The byte is committed only when the enable goes high again after exactly eight serial clock rises. Any other count leaves the stored value unchanged.

All three serial lines are sampled by the oscillator clock `osc_clk` through a two-stage synchronizer, and a rising edge of `ser_clk` is detected in that domain. The loader is a three-state machine:
- **IDLE** is the state while the enable is high.
- **IDLE → SHIFT** happens when the enable falls. The bit count is cleared.
- **SHIFT** takes one bit per serial clock rise. On a rise while the count is already 8, it moves **SHIFT → OVER**.
- **SHIFT → IDLE** happens when the enable rises. It commits the byte if the count is 8 and discards it otherwise.
- **OVER → IDLE** happens when the enable rises, and nothing is committed.

The stored bits then control several things: the polarity of the detector outputs, which phase detector drives the outputs, gating of the lock indication, a reference-output divider running from `osc_clk`, and gating of the two divided monitor outputs. The detectors, counters and lock detector sit outside the block, and their raw results arrive as inputs.

Top module: `pll_ctrl_reg`

## Requirements
- R1: Serial bits are taken, MSB first, on each synchronized rising edge of `ser_clk` while `ser_en_n` is low. The byte is stored as bit 7 = polarity, bit 6 = detector-A select, bit 5 = lock enable, bits 4..2 = reference select, bit 1 = VCO monitor enable, bit 0 = reference monitor enable. It is stored when `ser_en_n` returns high after exactly 8 rises.
- R2: A transfer that ends with a rise count other than 8 (0, 7, 9, ...) leaves the stored byte unchanged. The rise count restarts whenever the enable is high.
- R3: With bit 6 set, `pd_oe` is 1 and `phr_out`/`phv_out` are both held high. With bit 6 clear, `pd_oe` is 0 (the detector-A output is undriven) and the detector-B phases pass through.
- R4: With bit 7 set, `pd_out` is the inverse of `pfd_a_in`, and `phr_out` carries `pfd_v_in` while `phv_out` carries `pfd_r_in`. With bit 7 clear, neither is inverted or swapped.
- R5: `lock_out` equals `lock_in` when bit 5 is set and is 0 when it is clear.
- R6: Reference select code 0 gives `ref_out` = 0, and code 1 gives `osc_clk` itself. Codes 2, 3, 4 and 5 divide `osc_clk` by 2, 4, 8 and 16. Code 6 divides by 8 and code 7 by 16.
- R7: `fv_out` = `fv_in` when bit 1 is set, otherwise 0. `fr_out` = `fr_in` when bit 0 is set, otherwise 0.
- R8: After reset, the stored byte is 0x10: every enable and the polarity are clear, and the reference select is 4 (divide by 8).
- R9: The divider is a 4-bit counter that is cleared by reset and then increments on every `osc_clk` rise. Divided outputs are counter bits (50% duty), and changing the select code does not restart the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock; clocks all state and feeds the divider |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_clk | input | 1 | Serial shift clock |
| ser_dat | input | 1 | Serial data, MSB first |
| pfd_a_in | input | 1 | Raw single-ended output of detector A |
| pfd_r_in | input | 1 | Raw reference phase output of detector B |
| pfd_v_in | input | 1 | Raw VCO phase output of detector B |
| lock_in | input | 1 | Raw lock detector result |
| fr_in | input | 1 | Raw divided-reference monitor |
| fv_in | input | 1 | Raw divided-VCO monitor |
| pd_out | output | 1 | Detector A output data |
| pd_oe | output | 1 | Output enable for `pd_out` (0 = high impedance) |
| phr_out | output | 1 | Conditioned reference phase output |
| phv_out | output | 1 | Conditioned VCO phase output |
| lock_out | output | 1 | Gated lock indication |
| ref_out | output | 1 | Selected reference output |
| fr_out | output | 1 | Gated divided-reference monitor |
| fv_out | output | 1 | Gated divided-VCO monitor |

## Verification
The assertions assume that the serial lines change slowly compared with `osc_clk`, so that every high and low phase of `ser_clk` survives the synchronizer. They also assume that the data bit is stable before its clock rise. The stimulus holds each serial phase for four oscillator cycles and sets the data bit one full phase before the rise. Every one of the 256 byte values is loaded and checked against four raw-input patterns. The reference output is compared cycle by cycle against a counter model that starts at reset.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;

    localparam int CTRL_W = 8;

    typedef struct packed {
        logic       pol;
        logic       det_a_sel;
        logic       lock_en;
        logic [2:0] ref_sel;
        logic       fv_en;
        logic       fr_en;
    } ctrl_t;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_OVER  = 2'd2
    } ld_state_t;

endpackage

// File: rtl/pll_ser_loader.sv
module pll_ser_loader
    import pll_ctrl_pkg::*;
#(
    parameter int W    = 8,
    parameter int SYNC = 2,
    parameter logic [W-1:0] RESET_VAL = '0,
    localparam int CW  = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          sck,
    input  logic          sdi,
    output logic [W-1:0]  ctrl_q,
    output logic [CW-1:0] bit_cnt
);

    localparam logic [CW-1:0] FULL = CW'(W);

    logic [2:0] sync_q [SYNC];
    logic       sck_d;
    logic       en_s, sck_s, dat_s, sck_rise;

    for (genvar g = 0; g < SYNC; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q[g] <= 3'b010;
            end else if (g == 0) begin
                sync_q[g] <= {en_n, sck, sdi};
            end else begin
                sync_q[g] <= sync_q[g-1];
            end
        end
    end

    assign {en_s, sck_s, dat_s} = sync_q[SYNC-1];
    assign sck_rise = sck_s & ~sck_d;

    ld_state_t state_q, state_d;
    logic [W-1:0] shreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (!en_s) state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (en_s) state_d = ST_IDLE;
                else if (sck_rise && bit_cnt == FULL) state_d = ST_OVER;
            end
            ST_OVER:  if (en_s) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            shreg_q <= '0;
            bit_cnt <= '0;
            ctrl_q  <= RESET_VAL;
        end else begin
            sck_d <= sck_s;
            unique case (state_q)
                ST_IDLE: bit_cnt <= '0;
                ST_SHIFT: begin
                    if (en_s) begin
                        if (bit_cnt == FULL) ctrl_q <= shreg_q;
                        bit_cnt <= '0;
                    end else if (sck_rise && bit_cnt != FULL) begin
                        shreg_q <= {shreg_q[W-2:0], dat_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_OVER: bit_cnt <= '0;
                default: bit_cnt <= '0;
            endcase
        end
    end

endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
    parameter int DIV_BITS = 4,
    parameter int SEL_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             ref_out
);

    logic [DIV_BITS-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        unique case (sel)
            3'd0:    ref_out = 1'b0;
            3'd1:    ref_out = clk;
            3'd2:    ref_out = cnt_q[0];
            3'd3:    ref_out = cnt_q[1];
            3'd4:    ref_out = cnt_q[2];
            3'd5:    ref_out = cnt_q[3];
            3'd6:    ref_out = cnt_q[2];
            default: ref_out = cnt_q[DIV_BITS-1];
        endcase
    end

endmodule

// File: rtl/pll_out_cond.sv
module pll_out_cond
    import pll_ctrl_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  pfd_a_in,
    input  logic  pfd_r_in,
    input  logic  pfd_v_in,
    input  logic  lock_in,
    input  logic  fr_in,
    input  logic  fv_in,
    output logic  pd_out,
    output logic  pd_oe,
    output logic  phr_out,
    output logic  phv_out,
    output logic  lock_out,
    output logic  fr_out,
    output logic  fv_out
);

    logic r_sel, v_sel;

    always_comb begin
        r_sel    = ctrl.pol ? pfd_v_in : pfd_r_in;
        v_sel    = ctrl.pol ? pfd_r_in : pfd_v_in;
        pd_oe    = ctrl.det_a_sel;
        pd_out   = ctrl.det_a_sel & (pfd_a_in ^ ctrl.pol);
        phr_out  = ctrl.det_a_sel | r_sel;
        phv_out  = ctrl.det_a_sel | v_sel;
        lock_out = ctrl.lock_en & lock_in;
        fr_out   = ctrl.fr_en & fr_in;
        fv_out   = ctrl.fv_en & fv_in;
    end

endmodule

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
    import pll_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic ser_en_n,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic pfd_a_in,
    input  logic pfd_r_in,
    input  logic pfd_v_in,
    input  logic lock_in,
    input  logic fr_in,
    input  logic fv_in,
    output logic pd_out,
    output logic pd_oe,
    output logic phr_out,
    output logic phv_out,
    output logic lock_out,
    output logic ref_out,
    output logic fr_out,
    output logic fv_out
);

    localparam int CW = $clog2(CTRL_W + 1);

    logic [CTRL_W-1:0] ctrl_q;
    logic [CW-1:0]     bit_cnt;
    ctrl_t             ctrl;

    assign ctrl = ctrl_t'(ctrl_q);

    pll_ser_loader #(
        .W         (CTRL_W),
        .SYNC      (SYNC_STAGES),
        .RESET_VAL (CTRL_RESET)
    ) i_loader (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .en_n    (ser_en_n),
        .sck     (ser_clk),
        .sdi     (ser_dat),
        .ctrl_q  (ctrl_q),
        .bit_cnt (bit_cnt)
    );

    pll_ref_div #(
        .DIV_BITS (4),
        .SEL_W    (3)
    ) i_div (
        .clk     (osc_clk),
        .rst_n   (rst_n),
        .sel     (ctrl.ref_sel),
        .ref_out (ref_out)
    );

    pll_out_cond i_cond (
        .ctrl     (ctrl),
        .pfd_a_in (pfd_a_in),
        .pfd_r_in (pfd_r_in),
        .pfd_v_in (pfd_v_in),
        .lock_in  (lock_in),
        .fr_in    (fr_in),
        .fv_in    (fv_in),
        .pd_out   (pd_out),
        .pd_oe    (pd_oe),
        .phr_out  (phr_out),
        .phv_out  (phv_out),
        .lock_out (lock_out),
        .fr_out   (fr_out),
        .fv_out   (fv_out)
    );

endmodule

// File: rtl/pll_ctrl_chk.sv
module pll_ctrl_chk #(
    parameter int W  = 8,
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  ctrl_q,
    input logic [CW-1:0] bit_cnt,
    input logic          pd_oe,
    input logic          phr_out,
    input logic          phv_out,
    input logic          lock_in,
    input logic          lock_out,
    input logic          fr_in,
    input logic          fr_out,
    input logic          fv_in,
    input logic          fv_out,
    input logic          ref_out
);

    AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q != $past(ctrl_q)) |-> ($past(bit_cnt) == CW'(W))); // R1

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CW'(W)); // R2

    AST_DETB_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        pd_oe |-> (phr_out && phv_out)); // R3

    AST_LOCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        lock_out |-> lock_in); // R5

    AST_REF_STATIC: assert property (@(negedge clk) disable iff (!rst_n)
        (ctrl_q[4:2] == 3'd0) |-> !ref_out); // R6

    AST_FV_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        fv_out |-> fv_in); // R7

    AST_FR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        fr_out |-> fr_in); // R7

endmodule

bind pll_ctrl_reg pll_ctrl_chk #(.W(8), .CW(4)) i_chk (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .ctrl_q   (ctrl_q),
    .bit_cnt  (bit_cnt),
    .pd_oe    (pd_oe),
    .phr_out  (phr_out),
    .phv_out  (phv_out),
    .lock_in  (lock_in),
    .lock_out (lock_out),
    .fr_in    (fr_in),
    .fr_out   (fr_out),
    .fv_in    (fv_in),
    .fv_out   (fv_out),
    .ref_out  (ref_out)
);

// File: tb/test_pll_ctrl_reg.sv
`timescale 1ns/1ps
module test_pll_ctrl_reg;

    logic osc_clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
    logic pfd_a_in = 0, pfd_r_in = 0, pfd_v_in = 0, lock_in = 0, fr_in = 0, fv_in = 0;
    logic pd_out, pd_oe, phr_out, phv_out, lock_out, ref_out, fr_out, fv_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [3:0] mcnt;

    always #2 osc_clk = ~osc_clk;

    pll_ctrl_reg i_pll_ctrl_reg (
        .osc_clk(osc_clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
        .ser_dat(ser_dat), .pfd_a_in(pfd_a_in), .pfd_r_in(pfd_r_in), .pfd_v_in(pfd_v_in),
        .lock_in(lock_in), .fr_in(fr_in), .fv_in(fv_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .phr_out(phr_out), .phv_out(phv_out), .lock_out(lock_out), .ref_out(ref_out),
        .fr_out(fr_out), .fv_out(fv_out)
    );

    // R9 model: cycles since reset release, modulo 16
    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) mcnt <= '0;
        else        mcnt <= mcnt + 1'b1;
    end

    always @(posedge osc_clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge osc_clk);
        #1;
    endtask

    task automatic send(input logic [7:0] b, input int nclk);
        ser_en_n = 1'b0;
        wait_cyc(4);
        for (int i = 0; i < nclk; i++) begin
            ser_dat = (i < 8) ? b[7-i] : 1'b0;
            wait_cyc(4);
            ser_clk = 1'b1;
            wait_cyc(4);
            ser_clk = 1'b0;
        end
        wait_cyc(4);
        ser_en_n = 1'b1;
        wait_cyc(8);
    endtask

    function automatic int ref_tap(input logic [2:0] sel, input logic [3:0] m);
        case (sel)
            3'd0: return 0;
            3'd2: return int'(m[0]);
            3'd3: return int'(m[1]);
            3'd4, 3'd6: return int'(m[2]);
            default: return int'(m[3]);
        endcase
    endfunction

    // Check all gated outputs against the expected byte b
    task automatic check_outputs(input logic [7:0] b, input string tag);
        logic [5:0] pats [4] = '{6'b000000, 6'b111111, 6'b101010, 6'b010101};
        for (int p = 0; p < 4; p++) begin
            {pfd_a_in, pfd_r_in, pfd_v_in, lock_in, fr_in, fv_in} = pats[p];
            #0.5;
            check({tag, " R3 oe"}, int'(pd_oe), int'(b[6]));
            if (b[6]) check({tag, " R4 pd_out"}, int'(pd_out), int'(pfd_a_in ^ b[7]));
            check({tag, " R3/R4 phr"}, int'(phr_out),
                  int'(b[6] ? 1'b1 : (b[7] ? pfd_v_in : pfd_r_in)));
            check({tag, " R3/R4 phv"}, int'(phv_out),
                  int'(b[6] ? 1'b1 : (b[7] ? pfd_r_in : pfd_v_in)));
            check({tag, " R5 lock"}, int'(lock_out), int'(b[5] & lock_in));
            check({tag, " R7 fv"}, int'(fv_out), int'(b[1] & fv_in));
            check({tag, " R7 fr"}, int'(fr_out), int'(b[0] & fr_in));
        end
    endtask

    task automatic check_ref(input logic [2:0] sel, input string tag);
        int bad;
        bad = 0;
        if (sel == 3'd1) begin
            for (int i = 0; i < 4; i++) begin
                @(posedge osc_clk); #1;
                if (ref_out !== 1'b1) bad++;
                @(negedge osc_clk); #1;
                if (ref_out !== 1'b0) bad++;
            end
        end else begin
            for (int i = 0; i < 32; i++) begin
                @(posedge osc_clk); #1;
                if (int'(ref_out) != ref_tap(sel, mcnt)) bad++;
            end
        end
        check({tag, " R6/R9 ref mismatches"}, bad, 0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R8: power-up defaults (0x10)
        check_outputs(8'h10, "reset R8");
        check_ref(3'd4, "reset R8");

        // R1, R6, R9: every byte value, MSB first
        for (int v = 0; v < 256; v++) begin
            send(8'(v), 8);
            check_outputs(8'(v), $sformatf("R1 byte %02h", v));
            check_ref(3'(v >> 2), $sformatf("byte %02h", v));
        end

        // R2: wrong counts leave the register unchanged
        send(8'hE7, 8);
        send(8'h00, 7);
        check_outputs(8'hE7, "R2 seven clocks");
        send(8'h00, 9);
        check_outputs(8'hE7, "R2 nine clocks");
        send(8'h00, 0);
        check_outputs(8'hE7, "R2 zero clocks");
        check_ref(3'(8'hE7 >> 2), "R2 kept");
        send(8'h03, 8);
        check_outputs(8'h03, "R2 recovery R1");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule